// File: doc/BRIEF.md
# Indirect Host Register Port

This block connects an asynchronous 8-bit parallel host bus to a fast system clock domain. The host asserts chip select together with a read or write strobe and presents a 3-bit port number. Behind the small set of ports lies a wide internal register and table space. The host reaches it indirectly: it loads an address pointer through one port and then moves data through a second port. The pointer steps forward by one after every data access.

The strobes are synchronised into the system clock. Each command pulse is timed in system clocks against a minimum active length and a minimum idle gap. Pulses that break either rule have no effect. An accepted write acts when the pulse ends. An accepted data read issues a request on the internal bus and holds the host's wait line low until the data comes back. The data bus is driven only while a read pulse is active. Instead of true three-state pins, the block brings out separate output and output-enable signals.

Top module: `host_reg_port`

## Requirements
- R1: A command pulse exists only while chip select and a strobe are both low: read pulse = not(cs_n OR rd_n), write pulse = not(cs_n OR wr_n). A strobe with chip select high has no effect.
- R2: A pulse that is active for fewer than MIN_ACT (2) system clocks is ignored.
- R3: A pulse that begins after fewer than MIN_INH (4) idle system clocks since the previous pulse ended is ignored. An ignored read issues no internal read, leaves the data register unchanged and releases wait at once.
- R4: An accepted write takes effect at the end of its pulse. reg_wr is high for exactly one clock, in the third clock after the strobe rises, and carries the data and port present in the last active clock.
- R5: A write to port 0 shifts its byte into the low end of the ADDR_W-bit (16) pointer. The old low byte moves up into bits 15:8.
- R6: A write or read on port 1 accesses the pointer address and then increments the pointer by one. It wraps from all-ones to zero.
- R7: An accepted port 1 read raises reg_rd for one clock, MIN_ACT+1 clocks after the first sampled active clock. wait_n_o stays low until reg_rvalid returns the byte. The byte then appears on d_out and wait_n_o goes high.
- R8: A read of any port other than 1 returns 0x00 without an internal read. Writes to ports 2 to 7 have no effect.
- R9: d_oe is high exactly while a read pulse is present, so the bus is released as soon as the pulse ends.
- R10: wait_oe and ready_oe are high exactly while cs_n is low. ready_n_o is low during a write pulse, and during a read pulse once its data is ready.
- R11: After reset the pointer is zero, no internal request is active, and the data bus and handshakes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| ps | input | 3 | Port select |
| d_in | input | 8 | Host data bus, input side |
| d_out | output | 8 | Host data bus, output side |
| d_oe | output | 1 | Data bus output enable |
| wait_n_o | output | 1 | Wait handshake, active low |
| wait_oe | output | 1 | Wait output enable |
| ready_n_o | output | 1 | Ready handshake, active low |
| ready_oe | output | 1 | Ready output enable |
| reg_addr | output | ADDR_W | Internal access address |
| reg_wr | output | 1 | Internal write request, one clock |
| reg_wdata | output | 8 | Internal write data |
| reg_rd | output | 1 | Internal read request, one clock |
| reg_rdata | input | 8 | Internal read data |
| reg_rvalid | input | 1 | Internal read data valid |

## Verification
The pulse timing is tried with three kinds of stimulus:
- Pulses that meet the limits.
- Pulses exactly at the minimum length and minimum gap.
- Pulses one clock short of either limit.

Together these separate correct acceptance from an off-by-one in the active counter or the idle counter. Port traffic mixes address loads, data writes and reads, reads of unused ports, strobes without chip select, and a pointer wrap. This exposes wrong shift direction, missing increments and increments on ignored pulses. Each clock, internal requests are compared against a reference that predicts their exact cycle, address and data.

// File: rtl/host_reg_port.sv
module host_reg_port #(
  parameter int ADDR_W  = 16,
  parameter int MIN_ACT = 2,
  parameter int MIN_INH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [2:0]        ps,
  input  logic [7:0]        d_in,
  output logic [7:0]        d_out,
  output logic              d_oe,
  output logic              wait_n_o,
  output logic              wait_oe,
  output logic              ready_n_o,
  output logic              ready_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [7:0]        reg_wdata,
  output logic              reg_rd,
  input  logic [7:0]        reg_rdata,
  input  logic              reg_rvalid
);
  localparam int CW = $clog2(MIN_ACT + MIN_INH + 1) + 1;
  localparam logic [CW-1:0] ACT_MAX = CW'(MIN_ACT);
  localparam logic [CW-1:0] ACT_HIT = CW'(MIN_ACT - 1);
  localparam logic [CW-1:0] INH_MAX = CW'(MIN_INH);

  logic rd_raw, wr_raw;
  assign rd_raw = ~(cs_n | rd_n);
  assign wr_raw = ~(cs_n | wr_n);

  logic rs1, rs2, ws1, ws2;
  logic [7:0] dq1, dq2, wlat;
  logic [2:0] pq1, pq2, plat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rs1, rs2, ws1, ws2} <= '0;
      dq1 <= '0; dq2 <= '0; pq1 <= '0; pq2 <= '0;
      wlat <= '0; plat <= '0;
    end else begin
      rs1 <= rd_raw; rs2 <= rs1;
      ws1 <= wr_raw; ws2 <= ws1;
      dq1 <= d_in;   dq2 <= dq1;
      pq1 <= ps;     pq2 <= pq1;
      if (ws2) begin
        wlat <= dq2;
        plat <= pq2;
      end
    end
  end

  logic act, act_q, start, fin, hit, ok_now, ok_q, long_q, wr_kind;
  logic [CW-1:0] act_cnt, idle_cnt;
  assign act    = rs2 | ws2;
  assign start  = act & ~act_q;
  assign fin    = ~act & act_q;
  assign hit    = act & (act_cnt == ACT_HIT);
  assign ok_now = start ? (idle_cnt >= INH_MAX) : ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; act_cnt <= '0; idle_cnt <= INH_MAX;
      long_q <= 1'b0; wr_kind <= 1'b0;
    end else begin
      act_q <= act;
      if (act) begin
        act_cnt  <= (act_cnt == ACT_MAX) ? act_cnt : act_cnt + 1'b1;
        idle_cnt <= '0;
        wr_kind  <= ws2;
        if (hit) long_q <= 1'b1;
      end else begin
        act_cnt  <= '0;
        idle_cnt <= (idle_cnt == INH_MAX) ? idle_cnt : idle_cnt + 1'b1;
        long_q   <= 1'b0;
      end
    end
  end

  logic [ADDR_W-1:0] ptr;
  logic [7:0] dout;
  logic pend, rdy, rd_go;
  assign rd_go = rs2 & hit & ok_now & ~pend & (start | ~rdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0; ptr <= '0; dout <= '0; pend <= 1'b0; rdy <= 1'b0;
      reg_addr <= '0; reg_wr <= 1'b0; reg_wdata <= '0; reg_rd <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (start) begin
        ok_q <= ok_now;
        rdy  <= rs2 & ~ok_now;
      end
      if (fin) rdy <= 1'b0;
      if (fin & wr_kind & long_q & ok_q) begin
        if (plat == 3'd0) ptr <= {ptr[ADDR_W-9:0], wlat};
        else if (plat == 3'd1) begin
          reg_wr    <= 1'b1;
          reg_addr  <= ptr;
          reg_wdata <= wlat;
          ptr       <= ptr + 1'b1;
        end
      end
      if (rd_go) begin
        if (pq2 == 3'd1) begin
          reg_rd   <= 1'b1;
          reg_addr <= ptr;
          ptr      <= ptr + 1'b1;
          pend     <= 1'b1;
        end else begin
          dout <= 8'h00;
          rdy  <= 1'b1;
        end
      end
      if (pend & reg_rvalid) begin
        dout <= reg_rdata;
        rdy  <= 1'b1;
        pend <= 1'b0;
      end
    end
  end

  assign d_out     = dout;
  assign d_oe      = rd_raw;
  assign wait_oe   = ~cs_n;
  assign ready_oe  = ~cs_n;
  assign wait_n_o  = ~(rd_raw & ~rdy);
  assign ready_n_o = ~(wr_raw | (rd_raw & rdy));

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  assert_wr_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (!$past(ws2) && $past(ws2, 2)));
  assert_rd_during_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> $past(rs2));
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (ptr == reg_addr + 1'b1));
  assert_ready_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> !pend);
  assert_no_dual_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

// File: tb/host_reg_port_bench.sv
module host_reg_port_bench;
  localparam int CLK_P   = 10;
  localparam int MIN_ACT = 2;
  localparam int MIN_INH = 4;
  localparam int RLAT    = 3;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1;
  logic [2:0] ps = 0;
  logic [7:0] d_in = 0, reg_rdata = 0;
  logic reg_rvalid = 0;
  logic [7:0] d_out, reg_wdata;
  logic d_oe, wait_n_o, wait_oe, ready_n_o, ready_oe, reg_wr, reg_rd;
  logic [15:0] reg_addr;

  host_reg_port #(.ADDR_W(16), .MIN_ACT(MIN_ACT), .MIN_INH(MIN_INH)) u_host_reg_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ps(ps),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .wait_n_o(wait_n_o), .wait_oe(wait_oe),
    .ready_n_o(ready_n_o), .ready_oe(ready_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid));

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0, n_cmp = 0, n_bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] mem [int];
  logic [15:0] mptr = 0;
  logic [7:0] last_dout = 0;
  int last_rel = -100;
  int wdue[$], waddr[$], wdat[$], rdue[$], raddr[$];
  bit done = 0;

  function automatic logic [7:0] memval(int a);
    if (mem.exists(a)) return mem[a];
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // responder for internal reads
  int rcnt = 0, ra = 0;
  always @(negedge clk) begin
    reg_rvalid = 0;
    if (rcnt > 0) begin
      rcnt--;
      if (rcnt == 0) begin reg_rvalid = 1; reg_rdata = memval(ra); end
    end
    if (reg_rd) begin rcnt = RLAT; ra = int'(reg_addr); end
  end

  // per-clock comparison against the reference
  always @(negedge clk) if (rst_n && !done) begin
    chk(d_oe == (!cs_n && !rd_n), "R9", "d_oe", d_oe, !cs_n && !rd_n);
    chk(wait_oe == !cs_n && ready_oe == !cs_n, "R10", "oe", {wait_oe, ready_oe}, {2{!cs_n}});
    if (reg_wr) begin
      if (wdue.size() == 0) chk(0, "R4", "unexpected reg_wr addr", reg_addr, 0);
      else begin
        chk(wdue[0] == cyc, "R4", "reg_wr cycle", cyc, wdue[0]);
        chk(reg_addr == 16'(waddr[0]), "R6", "reg_wr addr", reg_addr, waddr[0]);
        chk(reg_wdata == 8'(wdat[0]), "R4", "reg_wr data", reg_wdata, wdat[0]);
        void'(wdue.pop_front()); void'(waddr.pop_front()); void'(wdat.pop_front());
      end
    end else if (wdue.size() > 0 && wdue[0] <= cyc) begin
      chk(0, "R4", "missing reg_wr", 0, wdue[0]);
      void'(wdue.pop_front()); void'(waddr.pop_front()); void'(wdat.pop_front());
    end
    if (reg_rd) begin
      if (rdue.size() == 0) chk(0, "R7", "unexpected reg_rd addr", reg_addr, 0);
      else begin
        chk(rdue[0] == cyc, "R7", "reg_rd cycle", cyc, rdue[0]);
        chk(reg_addr == 16'(raddr[0]), "R6", "reg_rd addr", reg_addr, raddr[0]);
        void'(rdue.pop_front()); void'(raddr.pop_front());
      end
    end else if (rdue.size() > 0 && rdue[0] <= cyc) begin
      chk(0, "R7", "missing reg_rd", 0, rdue[0]);
      void'(rdue.pop_front()); void'(raddr.pop_front());
    end
  end

  task automatic host_write(int port, logic [7:0] data, int len, int gap);
    int s, r;
    bit ok;
    repeat (gap) @(negedge clk);
    ps = 3'(port); d_in = data; cs_n = 0; wr_n = 0; s = cyc;
    repeat (len) @(negedge clk);
    chk(ready_n_o == 0, "R10", "ready during write", ready_n_o, 0);
    wr_n = 1; cs_n = 1; r = cyc;
    ok = (r - s >= MIN_ACT) && (s - last_rel >= MIN_INH);
    last_rel = r;
    if (ok && port == 0) mptr = {mptr[7:0], data};
    else if (ok && port == 1) begin
      wdue.push_back(r + 3); waddr.push_back(int'(mptr)); wdat.push_back(int'(data));
      mem[int'(mptr)] = data; mptr = mptr + 1;
    end
  endtask

  task automatic host_read(int port, int gap, string req);
    int s;
    bit ok;
    logic [7:0] exp;
    repeat (gap) @(negedge clk);
    ps = 3'(port); cs_n = 0; rd_n = 0; s = cyc;
    ok = (s - last_rel >= MIN_INH);
    if (!ok) exp = last_dout;
    else if (port == 1) begin
      rdue.push_back(s + MIN_ACT + 2); raddr.push_back(int'(mptr));
      exp = memval(int'(mptr)); mptr = mptr + 1;
    end else exp = 8'h00;
    @(negedge clk);
    if (ok && port == 1) chk(wait_n_o == 0, "R7", "wait low while pending", wait_n_o, 0);
    while (wait_n_o !== 1'b1) @(negedge clk);
    if (!ok) chk(cyc - s <= 3, "R3", "fast release of ignored read", cyc - s, 3);
    chk(d_out == exp, req, "read data", d_out, exp);
    chk(ready_n_o == 0 && d_oe == 1, "R10", "ready/oe at read end", {ready_n_o, d_oe}, 2'b01);
    last_dout = exp;
    @(negedge clk);
    rd_n = 1; cs_n = 1; last_rel = cyc;
    #1 chk(d_oe == 0, "R9", "bus released", d_oe, 0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reg_wr == 0 && reg_rd == 0, "R11", "requests in reset", {reg_wr, reg_rd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(d_oe == 0 && wait_oe == 0 && ready_oe == 0, "R11", "released after reset",
        {d_oe, wait_oe, ready_oe}, 0);
    // R11 pointer zero: first data write lands at 0
    host_write(1, 8'h5A, 3, 6);
    // R5 address load then R6 data writes
    host_write(0, 8'h12, 3, 6);
    host_write(0, 8'h34, 3, 6);
    host_write(1, 8'hAA, 3, 6);
    host_write(1, 8'hBB, 3, 6);
    host_write(0, 8'h12, 3, 6);
    host_write(0, 8'h34, 3, 6);
    host_read(1, 6, "R7");
    host_read(1, 6, "R7");
    host_read(1, 6, "R6");
    // R1 strobe without chip select
    repeat (6) @(negedge clk);
    wr_n = 0; d_in = 8'hEE; ps = 1;
    repeat (4) @(negedge clk);
    wr_n = 1;
    rd_n = 0;
    repeat (4) @(negedge clk);
    chk(d_oe == 0, "R1", "no bus drive without cs", d_oe, 0);
    rd_n = 1;
    host_write(1, 8'hC1, 3, 6);
    // R2 short pulse, then exact minimum length
    host_write(1, 8'hD1, 1, 6);
    host_write(1, 8'hD2, MIN_ACT, 6);
    // R3 gap too small, then exact minimum gap
    host_write(1, 8'hE1, 3, 6);
    host_write(1, 8'hE2, 3, MIN_INH - 1);
    host_write(1, 8'hE3, 3, MIN_INH);
    host_read(1, 6, "R7");
    host_read(1, MIN_INH - 1, "R3");
    // R8 other ports
    host_write(3, 8'h77, 3, 6);
    host_write(1, 8'h78, 3, 6);
    host_read(3, 6, "R8");
    host_read(0, 6, "R8");
    host_read(1, 6, "R8");
    // R6 wrap
    host_write(0, 8'hFF, 3, 6);
    host_write(0, 8'hFF, 3, 6);
    host_write(1, 8'h91, 3, 6);
    host_write(1, 8'h92, 3, 6);
    host_write(0, 8'hFF, 3, 6);
    host_write(0, 8'hFF, 3, 6);
    host_read(1, 6, "R6");
    host_read(1, 6, "R6");
    repeat (10) @(negedge clk);
    chk(wdue.size() == 0 && rdue.size() == 0, "R4", "outstanding expectations",
        wdue.size() + rdue.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule